// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Pipeline Sequencer

This block splits every instruction cycle into four sub-phases of the input clock. It uses those sub-phases to run a two-stage pipeline. During any one instruction cycle, the word at the current program address is fetched while the word fetched in the previous cycle executes. The sequencer owns the program counter, which advances by two per sequential instruction, and it presents the counter on the program-memory address port. At the end of each cycle it captures the returned instruction word into an instruction register. It also issues the data-memory read strobe and the data-memory write strobe in their fixed sub-phases.

The execute unit reports a taken branch through a flag and a target address. The sequencer samples both in the last sub-phase of the cycle. It then loads the target into the program counter and discards the word that was fetched alongside. The discarded word runs in the next cycle as a forced no-operation: the valid output is low and no data-memory strobe is issued. A branch therefore costs two instruction cycles. After reset, the first cycle only fetches and nothing executes. A quarter-rate cycle clock is brought out so that the instruction rhythm can be observed.

Top module: `phase_pipe_seq`

## Requirements
- R1: `phase` is one-hot in every clock after reset, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. During reset and in the first clock after it, `phase` = 4'b0001.
- R2: The sub-phases follow each other in the order Q1, Q2, Q3, Q4, Q1, and so on, one per input clock.
- R3: `cyc_clk` is high exactly during Q3 and Q4 and low during Q1 and Q2.
- R4: `pm_addr` resets to 0 and changes only at the start of Q1. Without a taken branch it grows by 2 per instruction cycle and wraps modulo 2^21.
- R5: `pm_data` is captured at the end of Q4. From the next Q1 it appears on `ir` for the whole execute cycle.
- R6: After reset, the first instruction cycle has `ir_valid` = 0. Every later cycle has `ir_valid` = 1, except a flushed slot.
- R7: `dm_rd` is high only in Q2 of a cycle with `ir_valid` = 1. `dm_wr` is high only in Q4 of such a cycle.
- R8: If `br_taken` is high at the end of Q4 in a cycle with `ir_valid` = 1, the next cycle fetches from `br_tgt` and has `ir_valid` = 0. The cycle after that executes the word at `br_tgt` and fetches from `br_tgt` + 2.
- R9: `br_taken` has no effect in a cycle with `ir_valid` = 0. The program counter then advances by 2 and the next cycle is valid.
- R10: A reset asserted in any sub-phase returns the block to Q1 with `pm_addr` = 0, `ir_valid` = 0 and both data strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| pm_addr | output | 21 | Program-memory fetch address |
| pm_data | input | 16 | Instruction word returned by program memory |
| br_taken | input | 1 | Executing instruction redirects the program counter |
| br_tgt | input | 21 | Branch target address |
| phase | output | 4 | One-hot sub-phase strobes, bit 0 = Q1 … bit 3 = Q4 |
| cyc_clk | output | 1 | Quarter-rate clock, high in Q3 and Q4 |
| ir | output | 16 | Instruction register (instruction in execute) |
| ir_valid | output | 1 | Executing slot is a real instruction |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |

## Verification
A phase counter that slips moves the data strobes and `cyc_clk` into the wrong input clock. This shows at the ports within one clock, and the bench checks each sub-phase of every cycle. A corrupted program counter or a missed redirect shows on `pm_addr` at the very next Q1. A flush flag left set, or never set, shows on `ir_valid` and the strobes in the cycle right after a branch. The bench walks a table of cycles that covers the reset fetch-only slot, sequential steps, a branch, a branch ignored in a flushed slot and address wrap. It then applies a reset in the middle of a cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int NUM_PH = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } ph_e;

    // Sub-phase that follows the given one.
    function automatic ph_e ph_next(input ph_e p);
        return ph_e'(p + 2'd1);
    endfunction
endpackage

// File: rtl/pps_phase_gen.sv
module pps_phase_gen
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [NUM_PH-1:0] phase,
    output logic              cyc_clk,
    output logic              cyc_end
);
    ph_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_Q1;
        else     ph_q <= ph_next(ph_q);
    end

    for (genvar i = 0; i < NUM_PH; i++) begin : g_dec
        assign phase[i] = (ph_q == ph_e'(i));
    end

    assign cyc_clk = (ph_q == PH_Q3) || (ph_q == PH_Q4);
    assign cyc_end = (ph_q == PH_Q4);

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);
    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        phase[0] |=> phase[1]);
    // R3
    cyc_clk_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_clk |-> (phase[2] || phase[3]));
endmodule

// File: rtl/pps_fetch.sv
module pps_fetch #(
    parameter int PC_W    = 21,
    parameter int IW      = 16,
    parameter int PC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_end,
    input  logic [IW-1:0]   pm_data,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_tgt,
    output logic [PC_W-1:0] pc,
    output logic [IW-1:0]   ir,
    output logic            ir_valid
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    logic redirect;
    assign redirect = ir_valid && br_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            ir       <= '0;
            ir_valid <= 1'b0;
        end else if (cyc_end) begin
            pc       <= redirect ? br_tgt : pc + STEP;
            ir       <= pm_data;
            ir_valid <= !redirect;
        end
    end

    // R4
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_end |=> $stable(pc));
    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && ir_valid && br_taken) |=> !ir_valid);
    // R9
    no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && !ir_valid) |=> ir_valid);
endmodule

// File: rtl/pps_strobe.sv
module pps_strobe
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PH-1:0] phase,
    input  logic              ir_valid,
    output logic              dm_rd,
    output logic              dm_wr
);
    assign dm_rd = ir_valid && phase[PH_Q2];
    assign dm_wr = ir_valid && phase[PH_Q4];

    // R7
    rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
        dm_rd |-> (phase[1] && !dm_wr));
    // R7
    wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        dm_wr |-> (phase[3] && !dm_rd));
endmodule

// File: rtl/phase_pipe_seq.sv
module phase_pipe_seq
    import pps_pkg::*;
#(
    parameter int PC_W    = 21,
    parameter int IW      = 16,
    parameter int PC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] pm_addr,
    input  logic [IW-1:0]   pm_data,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_tgt,
    output logic [3:0]      phase,
    output logic            cyc_clk,
    output logic [IW-1:0]   ir,
    output logic            ir_valid,
    output logic            dm_rd,
    output logic            dm_wr
);
    logic cyc_end;

    pps_phase_gen u_ph (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cyc_clk (cyc_clk),
        .cyc_end (cyc_end)
    );

    pps_fetch #(.PC_W(PC_W), .IW(IW), .PC_STEP(PC_STEP)) u_fe (
        .clk      (clk),
        .rst      (rst),
        .cyc_end  (cyc_end),
        .pm_data  (pm_data),
        .br_taken (br_taken),
        .br_tgt   (br_tgt),
        .pc       (pm_addr),
        .ir       (ir),
        .ir_valid (ir_valid)
    );

    pps_strobe u_st (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .ir_valid (ir_valid),
        .dm_rd    (dm_rd),
        .dm_wr    (dm_wr)
    );

    // R5
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !phase[3] |=> $stable(ir));
    // R6
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !phase[3] |=> $stable(ir_valid));
endmodule

// File: tb/sim_phase_pipe_seq.sv
module sim_phase_pipe_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [20:0] pm_addr;
    logic [15:0] pm_data;
    logic        br_taken;
    logic [20:0] br_tgt;
    logic [3:0]  phase;
    logic        cyc_clk;
    logic [15:0] ir;
    logic        ir_valid;
    logic        dm_rd;
    logic        dm_wr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_pipe_seq u0 (
        .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_data(pm_data),
        .br_taken(br_taken), .br_tgt(br_tgt), .phase(phase),
        .cyc_clk(cyc_clk), .ir(ir), .ir_valid(ir_valid),
        .dm_rd(dm_rd), .dm_wr(dm_wr)
    );

    typedef struct packed {
        logic [15:0] data;
        logic        br;
        logic [20:0] tgt;
        logic [20:0] e_addr;
        logic        e_valid;
        logic [15:0] e_ir;
    } vec_t;

    // One row per instruction cycle: inputs driven in that cycle and
    // values expected at its Q1.
    localparam int NV = 9;
    localparam vec_t VEC [0:NV-1] = '{
        '{16'hA000, 1'b1, 21'h000100, 21'h000000, 1'b0, 16'h0000}, // R6 R9 fetch-only, branch ignored
        '{16'hA001, 1'b0, 21'h000000, 21'h000002, 1'b1, 16'hA000}, // R4 R5
        '{16'hA002, 1'b1, 21'h000040, 21'h000004, 1'b1, 16'hA001}, // R8 branch taken
        '{16'hA003, 1'b1, 21'h000080, 21'h000040, 1'b0, 16'hA002}, // R8 flushed, R9 ignored
        '{16'hA004, 1'b0, 21'h000000, 21'h000042, 1'b1, 16'hA003}, // R8 target executes
        '{16'hA005, 1'b1, 21'h1FFFFE, 21'h000044, 1'b1, 16'hA004},
        '{16'hA006, 1'b0, 21'h000000, 21'h1FFFFE, 1'b0, 16'hA005},
        '{16'hA007, 1'b0, 21'h000000, 21'h000000, 1'b1, 16'hA006}, // R4 wrap
        '{16'hA008, 1'b0, 21'h000000, 21'h000002, 1'b1, 16'hA007}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at the negedge in Q1; returns at the negedge of the next Q1.
    task automatic run_cycle(input vec_t v);
        chk("R1 phase Q1", 32'(phase), 32'h1);
        chk("R3 cyc_clk low Q1", 32'(cyc_clk), 32'h0);
        chk("R4 pm_addr", 32'(pm_addr), 32'(v.e_addr));
        chk("R6 ir_valid", 32'(ir_valid), 32'(v.e_valid));
        if (v.e_valid) chk("R5 ir", 32'(ir), 32'(v.e_ir));
        pm_data  = v.data;
        br_taken = v.br;
        br_tgt   = v.tgt;
        @(negedge clk);
        chk("R2 phase Q2", 32'(phase), 32'h2);
        chk("R7 dm_rd Q2", 32'(dm_rd), 32'(v.e_valid));
        chk("R3 cyc_clk low Q2", 32'(cyc_clk), 32'h0);
        @(negedge clk);
        chk("R2 phase Q3", 32'(phase), 32'h4);
        chk("R3 cyc_clk high Q3", 32'(cyc_clk), 32'h1);
        chk("R7 no strobe Q3", 32'({dm_rd, dm_wr}), 32'h0);
        @(negedge clk);
        chk("R2 phase Q4", 32'(phase), 32'h8);
        chk("R7 dm_wr Q4", 32'(dm_wr), 32'(v.e_valid));
        chk("R4 pm_addr stable in cycle", 32'(pm_addr), 32'(v.e_addr));
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; pm_data = '0; br_taken = 1'b0; br_tgt = '0;
        repeat (3) @(negedge clk);
        // R1 R10 reset state
        chk("R1 reset phase", 32'(phase), 32'h1);
        chk("R10 reset pm_addr", 32'(pm_addr), 32'h0);
        chk("R10 reset ir_valid", 32'(ir_valid), 32'h0);
        chk("R10 reset strobes", 32'({dm_rd, dm_wr}), 32'h0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) run_cycle(VEC[i]);

        // R10: reset asserted in Q3 of a running cycle
        @(negedge clk);
        @(negedge clk);
        chk("R10 pre-reset phase Q3", 32'(phase), 32'h4);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 phase back to Q1", 32'(phase), 32'h1);
        chk("R10 pm_addr cleared", 32'(pm_addr), 32'h0);
        chk("R10 ir_valid cleared", 32'(ir_valid), 32'h0);
        chk("R10 strobes low", 32'({dm_rd, dm_wr}), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        // R6 R9: restart with a fetch-only slot; a branch there is ignored
        run_cycle('{16'hB000, 1'b1, 21'h000300, 21'h000000, 1'b0, 16'h0000});
        run_cycle('{16'hB001, 1'b0, 21'h000000, 21'h000002, 1'b1, 16'hB000});
        run_cycle('{16'hB002, 1'b0, 21'h000000, 21'h000004, 1'b1, 16'hB001});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule